// File: doc/BRIEF.md
# Configurable-Frame Serial Receiver

This block receives asynchronous serial characters on a single input line. The frame shape is set by an 8-bit configuration word: the number of data bits (four to nine), whether a parity bit follows and of which sense, and how long the stop period is. An external strobe marks sixteen equal slices of every bit period. The block counts these slices to find the middle of each bit. Baud-rate generation, bus access and pin routing belong to the surrounding logic.

Each finished character is packed with its parity and framing error flags into one 16-bit receive word. The word goes into a two-entry buffer. The oldest entry appears on `rxWord` and is removed by a one-cycle read strobe. A line break is reported as an all-zero character with the framing flag set. A character that arrives while the buffer is full is lost, and a sticky overflow flag records the loss. One-cycle commands switch reception on and off. The receiver is off after reset.

Top module: `cfg_uart_rx`

## Requirements
- R1: Configuration bits [3:0] hold the data length as bit count minus 3. Codes 1..6 select 4..9 data bits. Code 0 is read as 4 bits and codes above 6 as 9 bits. Data arrives least significant bit first and lands right-aligned in `rxWord[8:0]`, with unused high data bits zero.
- R2: Configuration bits [5:4] select parity: 00 or 01 means no parity bit, 10 means even and 11 means odd. A parity bit that disagrees with the selected sense sets `rxWord[14]`. Without parity, bit 14 is 0.
- R3: Configuration bits [7:6] set the stop length: 00 half, 01 or 10 one, 11 two. Only the first stop bit is examined. It is sampled on slice 4 in half mode and on slice 8 otherwise. A low sample sets `rxWord[15]`.
- R4: `rxWord[13:9]` always reads 0.
- R5: A line held low through the whole frame, stop bit included, yields a word with bit 15 set and data 0.
- R6: A start bit is accepted only if at least two of the samples on slices 7, 8 and 9 are low. Otherwise the receiver returns to idle and delivers nothing.
- R7: The buffer holds two words. `rxValid` is high while it holds at least one. `rxWord` shows the oldest word, or 0 when the buffer is empty. A read strobe removes the shown word at the end of that cycle. A strobe while empty has no effect.
- R8: A character that completes while the buffer is full and no read is under way is dropped. It sets `rxOverflow` and leaves the stored words unchanged. The flag stays set across reads.
- R9: When a character completes in the same cycle that a read removes an entry from a full buffer, the removal happens first. The new character is stored and no overflow is flagged.
- R10: `rxEnCmd` turns reception on and `rxDisCmd` turns it off. If both arrive in the same cycle, the receiver ends up off. While off, line activity produces no words.
- R11: `rxDisCmd` clears `rxOverflow`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick16 | input | 1 | One-cycle strobe, sixteen per bit period |
| rxLine | input | 1 | Asynchronous serial input, idle high |
| cfgWord | input | 8 | Frame configuration: [3:0] length, [5:4] parity, [7:6] stop |
| rxEnCmd | input | 1 | One-cycle enable command |
| rxDisCmd | input | 1 | One-cycle disable command, also clears overflow |
| rdStrobe | input | 1 | Removes the word shown on rxWord |
| rxWord | output | 16 | Oldest word: [15] framing error, [14] parity error, [8:0] data |
| rxValid | output | 1 | Buffer holds at least one word |
| rxOverflow | output | 1 | Sticky flag: a character was dropped |

## Verification
Completing a character and removing a word can happen in the same clock cycle. This matters most when the buffer is already full. To provoke it, the bench fills both entries and then sends a third character. It raises the read strobe in exactly the cycle of the stop-bit sampling slice, which it finds by counting slices from the moment it pulled the line low. The result is judged at the ports: the overflow flag must stay low, and the next two reads must return the second and third characters. A separate run without the read confirms that the third character is dropped and the overflow flag is raised.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  localparam int MAX_BITS = 9;
  localparam int WORD_W   = 16;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rxState_t;

  typedef struct packed {
    logic       clrChar;
    logic       takeData;
    logic       takePar;
    logic       takeStop;
    logic       clrOvf;
    logic [3:0] bitIdx;
  } rxStrobe_t;

  function automatic logic [3:0] dataBits(input logic [3:0] code);
    if (code < 4'd1)      return 4'd4;
    else if (code > 4'd6) return 4'd9;
    else                  return code + 4'd3;
  endfunction

endpackage

// File: rtl/uart_rx_ctl.sv
module uart_rx_ctl
  import uart_rx_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      tick,
  input  logic      lineS,
  input  logic [7:0] cfgWord,
  input  logic      enCmd,
  input  logic      disCmd,
  output rxStrobe_t stb
);

  rxState_t   state;
  logic [3:0] slotCnt;
  logic [3:0] bitIdx;
  logic       enabled;
  logic       vote7, vote8;

  logic [3:0] slot;
  logic [3:0] nData;
  logic       parOn;
  logic [3:0] stopSlot;
  logic [1:0] lowCount;
  logic       active;

  assign slot     = slotCnt + 4'd1;
  assign nData    = dataBits(cfgWord[3:0]);
  assign parOn    = cfgWord[5];
  assign stopSlot = (cfgWord[7:6] == 2'b00) ? 4'd4 : 4'd8;
  assign lowCount = {1'b0, ~vote7} + {1'b0, ~vote8} + {1'b0, ~lineS};
  assign active   = enabled && !disCmd;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      slotCnt <= '0;
      bitIdx  <= '0;
      enabled <= 1'b0;
      vote7   <= 1'b1;
      vote8   <= 1'b1;
    end else begin
      if (disCmd)     enabled <= 1'b0;
      else if (enCmd) enabled <= 1'b1;

      if (!active) begin
        state <= ST_IDLE;
      end else if (tick) begin
        case (state)
          ST_IDLE: begin
            if (!lineS) begin
              state   <= ST_START;
              slotCnt <= '0;
            end
          end
          ST_START: begin
            slotCnt <= slot;
            if (slot == 4'd7) vote7 <= lineS;
            if (slot == 4'd8) vote8 <= lineS;
            if (slot == 4'd9 && lowCount < 2'd2) state <= ST_IDLE;
            else if (slot == 4'd15) begin
              state  <= ST_DATA;
              bitIdx <= '0;
            end
          end
          ST_DATA: begin
            slotCnt <= slot;
            if (slot == 4'd15) begin
              if (bitIdx == nData - 4'd1) state <= parOn ? ST_PAR : ST_STOP;
              else                        bitIdx <= bitIdx + 4'd1;
            end
          end
          ST_PAR: begin
            slotCnt <= slot;
            if (slot == 4'd15) state <= ST_STOP;
          end
          ST_STOP: begin
            slotCnt <= slot;
            if (slot == stopSlot) state <= ST_IDLE;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    stb          = '0;
    stb.bitIdx   = bitIdx;
    stb.clrOvf   = disCmd;
    stb.clrChar  = active && tick && (state == ST_IDLE) && !lineS;
    stb.takeData = active && tick && (state == ST_DATA) && (slot == 4'd8);
    stb.takePar  = active && tick && (state == ST_PAR)  && (slot == 4'd8);
    stb.takeStop = active && tick && (state == ST_STOP) && (slot == stopSlot);
  end

  AST_OFF_GOES_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!enabled) |=> (state == ST_IDLE)); // R10

  AST_GLITCH_REJECT: assert property (@(posedge clk) disable iff (!rstN)
    (active && tick && state == ST_START && slot == 4'd9 && lowCount < 2'd2)
      |=> (state == ST_IDLE)); // R6

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.clrChar, stb.takeData, stb.takePar, stb.takeStop})); // R1

endmodule

// File: rtl/uart_rx_dp.sv
module uart_rx_dp
  import uart_rx_pkg::*;
#(
  parameter int DEPTH = 2
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxLine,
  input  logic [1:0]        parMode,
  input  rxStrobe_t         stb,
  input  logic              rdStrobe,
  output logic              lineS,
  output logic [WORD_W-1:0] rxWord,
  output logic              rxValid,
  output logic              rxOverflow
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic                sync1, sync2;
  logic [MAX_BITS-1:0] dataReg;
  logic                parAcc;
  logic                parErr;

  logic [WORD_W-1:0]   mem [DEPTH];
  logic [PTR_W-1:0]    wrPtr, rdPtr;
  logic [CNT_W-1:0]    count;

  logic                doPop, doPush;
  logic [WORD_W-1:0]   newWord;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign lineS   = sync2;
  assign newWord = {~lineS, parErr, 5'b00000, dataReg};
  assign doPop   = rdStrobe && (count != '0);
  assign doPush  = stb.takeStop && ((count != FULL) || doPop);
  assign rxValid = (count != '0);
  assign rxWord  = rxValid ? mem[rdPtr] : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sync1   <= 1'b1;
      sync2   <= 1'b1;
      dataReg <= '0;
      parAcc  <= 1'b0;
      parErr  <= 1'b0;
    end else begin
      sync1 <= rxLine;
      sync2 <= sync1;
      if (stb.clrChar) begin
        dataReg <= '0;
        parAcc  <= 1'b0;
        parErr  <= 1'b0;
      end
      if (stb.takeData) begin
        dataReg[stb.bitIdx] <= lineS;
        parAcc              <= parAcc ^ lineS;
      end
      if (stb.takePar) parErr <= parAcc ^ lineS ^ parMode[0];
    end
  end

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= newWord;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr      <= '0;
      rdPtr      <= '0;
      count      <= '0;
      rxOverflow <= 1'b0;
    end else begin
      if (doPop)  rdPtr <= nextPtr(rdPtr);
      if (doPush) wrPtr <= nextPtr(wrPtr);
      case ({doPush, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (stb.clrOvf) rxOverflow <= 1'b0;
      if (stb.takeStop && !doPush) rxOverflow <= 1'b1;
    end
  end

  AST_POP_SHRINKS: assert property (@(posedge clk) disable iff (!rstN)
    (doPop && !stb.takeStop) |=> (count == $past(count) - 1'b1)); // R7

  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (stb.takeStop && count == FULL && !rdStrobe) |=> (rxOverflow && count == FULL)); // R8

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (rxOverflow && !stb.clrOvf) |=> rxOverflow); // R8

  AST_SWAP_WHEN_FULL: assert property (@(posedge clk) disable iff (!rstN)
    (stb.takeStop && rdStrobe && count == FULL)
      |=> (count == FULL && rxOverflow == $past(rxOverflow))); // R9

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |-> (rxWord[13:9] == 5'b00000)); // R4

endmodule

// File: rtl/cfg_uart_rx.sv
module cfg_uart_rx
  import uart_rx_pkg::*;
#(
  parameter int DEPTH = 2
)(
  input  logic        clk,
  input  logic        rstN,
  input  logic        tick16,
  input  logic        rxLine,
  input  logic [7:0]  cfgWord,
  input  logic        rxEnCmd,
  input  logic        rxDisCmd,
  input  logic        rdStrobe,
  output logic [15:0] rxWord,
  output logic        rxValid,
  output logic        rxOverflow
);

  rxStrobe_t stb;
  logic      lineS;

  uart_rx_ctl u_ctl (
    .clk     (clk),
    .rstN    (rstN),
    .tick    (tick16),
    .lineS   (lineS),
    .cfgWord (cfgWord),
    .enCmd   (rxEnCmd),
    .disCmd  (rxDisCmd),
    .stb     (stb)
  );

  uart_rx_dp #(.DEPTH(DEPTH)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .rxLine     (rxLine),
    .parMode    (cfgWord[5:4]),
    .stb        (stb),
    .rdStrobe   (rdStrobe),
    .lineS      (lineS),
    .rxWord     (rxWord),
    .rxValid    (rxValid),
    .rxOverflow (rxOverflow)
  );

endmodule

// File: tb/cfg_uart_rx_tb.sv
module cfg_uart_rx_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rxLine = 1'b1;
  logic [7:0]  cfgWord = 8'h45;
  logic        rxEnCmd = 1'b0;
  logic        rxDisCmd = 1'b0;
  logic        rdStrobe = 1'b0;
  logic [15:0] rxWord;
  logic        rxValid;
  logic        rxOverflow;
  logic [1:0]  phase = 2'd0;
  logic        tick16;

  int nChk = 0;
  int nFail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  always @(posedge clk) phase <= phase + 2'd1;
  assign tick16 = (phase == 2'd3);

  cfg_uart_rx u_dut (
    .clk(clk), .rstN(rstN), .tick16(tick16), .rxLine(rxLine),
    .cfgWord(cfgWord), .rxEnCmd(rxEnCmd), .rxDisCmd(rxDisCmd),
    .rdStrobe(rdStrobe), .rxWord(rxWord), .rxValid(rxValid),
    .rxOverflow(rxOverflow)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic waitTick();
    do @(negedge clk); while (!tick16);
  endtask

  task automatic pulseEn();
    @(negedge clk) rxEnCmd = 1'b1;
    @(negedge clk) rxEnCmd = 1'b0;
  endtask

  task automatic pulseDis();
    @(negedge clk) rxDisCmd = 1'b1;
    @(negedge clk) rxDisCmd = 1'b0;
  endtask

  function automatic int lenOf(input logic [3:0] code);
    if (code < 4'd1) return 4;
    if (code > 4'd6) return 9;
    return int'(code) + 3;
  endfunction

  task automatic sendFrame(input logic [8:0] d, input bit flipPar, input bit stopVal,
                           input bit popAtStop);
    int nd = lenOf(cfgWord[3:0]);
    logic p = 1'b0;
    waitTick();
    rxLine = 1'b0;
    repeat (16) waitTick();
    for (int j = 0; j < nd; j++) begin
      rxLine = d[j];
      p = p ^ d[j];
      repeat (16) waitTick();
    end
    if (cfgWord[5]) begin
      rxLine = p ^ cfgWord[4] ^ flipPar;
      repeat (16) waitTick();
    end
    rxLine = stopVal;
    repeat ((cfgWord[7:6] == 2'b00) ? 5 : 9) waitTick();
    rxLine = 1'b1;
    if (popAtStop) begin
      rdStrobe = 1'b1;
      @(negedge clk) rdStrobe = 1'b0;
    end
    repeat (32) waitTick();
  endtask

  function automatic logic [15:0] expWord(input logic [8:0] d, input int nd,
                                          input bit pe, input bit fe);
    logic [8:0] m = 9'((1 << nd) - 1);
    return {fe, pe, 5'b00000, d & m};
  endfunction

  task automatic readChk(input string req, input logic [15:0] exp);
    @(negedge clk);
    chk(req, {31'b0, rxValid}, 32'd1);
    chk(req, {16'b0, rxWord}, {16'b0, exp});
    rdStrobe = 1'b1;
    @(negedge clk) rdStrobe = 1'b0;
  endtask

  task automatic emptyChk(input string req);
    @(negedge clk);
    chk(req, {31'b0, rxValid}, 32'd0);
    chk(req, {16'b0, rxWord}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFail++;
      nChk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    // R7 R10: reset state
    emptyChk("R7 reset");
    chk("R8 reset", {31'b0, rxOverflow}, 32'd0);

    // R10: receiver is off after reset, character ignored
    sendFrame(9'h0A5, 0, 1, 0);
    emptyChk("R10 off after reset");
    pulseEn();

    // R1 R2: sweep length codes and parity modes
    for (int lc = 1; lc <= 6; lc++) begin
      for (int pi = 0; pi < 3; pi++) begin
        logic [1:0] pm = (pi == 0) ? 2'b00 : (pi == 1) ? 2'b10 : 2'b11;
        cfgWord = {2'b01, pm, 4'(lc)};
        for (int v = 0; v < 2; v++) begin
          logic [8:0] d = 9'(lc * 71 + pi * 29 + v * 173);
          bit flip = (v == 1) && (pm != 2'b00);
          sendFrame(d, flip, 1, 0);
          readChk("R1 R2 sweep", expWord(d, lc + 3, flip, 0));
        end
      end
    end

    // R2: mode 01 behaves as no parity
    cfgWord = 8'h55;
    sendFrame(9'h0C3, 0, 1, 0);
    readChk("R2 mode01", expWord(9'h0C3, 8, 0, 0));

    // R1: out-of-range length codes clamp
    cfgWord = 8'h40;
    sendFrame(9'h1A5, 0, 1, 0);
    readChk("R1 code0", expWord(9'h1A5, 4, 0, 0));
    cfgWord = 8'h4F;
    sendFrame(9'h1A5, 0, 1, 0);
    readChk("R1 code15", expWord(9'h1A5, 9, 0, 0));

    // R3: stop modes, good and bad first stop bit
    for (int si = 0; si < 3; si++) begin
      logic [1:0] sm = (si == 0) ? 2'b00 : (si == 1) ? 2'b01 : 2'b11;
      cfgWord = {sm, 2'b00, 4'd5};
      sendFrame(9'h03C, 0, 1, 0);
      readChk("R3 stop ok", expWord(9'h03C, 8, 0, 0));
      sendFrame(9'h03C, 0, 0, 0);
      readChk("R3 stop bad", expWord(9'h03C, 8, 0, 1));
    end

    // R5: break
    cfgWord = 8'h45;
    sendFrame(9'h000, 0, 0, 0);
    readChk("R5 break R4", 16'h8000);

    // R6: short glitch rejected, receiver still works afterwards
    waitTick();
    rxLine = 1'b0;
    repeat (6) waitTick();
    rxLine = 1'b1;
    repeat (48) waitTick();
    emptyChk("R6 glitch");
    sendFrame(9'h05A, 0, 1, 0);
    readChk("R6 after glitch", expWord(9'h05A, 8, 0, 0));

    // R7: two-deep ordering, read while empty ignored
    sendFrame(9'h011, 0, 1, 0);
    sendFrame(9'h022, 0, 1, 0);
    chk("R8 no ovf at 2", {31'b0, rxOverflow}, 32'd0);
    readChk("R7 first", 16'h0011);
    readChk("R7 second", 16'h0022);
    emptyChk("R7 drained");
    @(negedge clk) rdStrobe = 1'b1;
    @(negedge clk) rdStrobe = 1'b0;
    sendFrame(9'h033, 0, 1, 0);
    readChk("R7 after empty read", 16'h0033);

    // R8: third character dropped, flag sticky
    sendFrame(9'h041, 0, 1, 0);
    sendFrame(9'h042, 0, 1, 0);
    sendFrame(9'h043, 0, 1, 0);
    @(negedge clk);
    chk("R8 ovf set", {31'b0, rxOverflow}, 32'd1);
    readChk("R8 kept first", 16'h0041);
    readChk("R8 kept second", 16'h0042);
    emptyChk("R8 drop");
    chk("R8 sticky", {31'b0, rxOverflow}, 32'd1);

    // R11: disable clears overflow
    pulseDis();
    @(negedge clk);
    chk("R11 clear", {31'b0, rxOverflow}, 32'd0);

    // R10: while off, ignored; then on again
    sendFrame(9'h077, 0, 1, 0);
    emptyChk("R10 disabled");
    pulseEn();

    // R9: completion and read in the same cycle with a full buffer
    sendFrame(9'h051, 0, 1, 0);
    sendFrame(9'h052, 0, 1, 0);
    sendFrame(9'h053, 0, 1, 1);
    @(negedge clk);
    chk("R9 no ovf", {31'b0, rxOverflow}, 32'd0);
    readChk("R9 second", 16'h0052);
    readChk("R9 third", 16'h0053);
    emptyChk("R9 drained");

    // R10: enable and disable in the same cycle leaves it off
    @(negedge clk) begin rxEnCmd = 1'b1; rxDisCmd = 1'b1; end
    @(negedge clk) begin rxEnCmd = 1'b0; rxDisCmd = 1'b0; end
    sendFrame(9'h066, 0, 1, 0);
    emptyChk("R10 both cmds");

    done = 1;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

endmodule